// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block is a 512-word by 18-bit queue between two unrelated clock domains. Each rising edge of the write clock stores the word on the input bus unless the queue is full. Each rising edge of the read clock discards the word at the head unless the queue is empty. The clocks act as strobes, so an edge is itself the request. The head word is always visible on the read data bus, and a valid qualifier marks it. No read edge is needed to see the first word after the queue was empty.

The read and write pointers cross between domains as Gray code through a synchronizer chain of two flops. The full and half-full flags come from write-side state. The empty flag comes from read-side state. Each flag follows the activity of its own side on the next edge. It follows the other side only after two edges of its own clock. An active-low reset takes effect at once in both domains. Each domain leaves reset on its own clock. A disable input forces the valid qualifier low and leaves the data bus as it is.

Top module: `dc_fwft_fifo`

## Requirements
- R1: Words leave in the order they entered. The queue holds up to 512 words of 18 bits each.
- R2: A rising write-clock edge stores `wrData` only while `fullN` is high. Write edges while `fullN` is low leave the stored contents unchanged.
- R3: A rising read-clock edge removes the head word only while `emptyN` is high. Read edges while `emptyN` is low change nothing.
- R4: `fullN` goes low right after the write edge that brings the write-side count to 512, and is high otherwise. Reads reach this count after two write-clock edges.
- R5: `emptyN` is low when the read side sees no words. It goes low right after the read edge that removes the last visible word. It goes high only on the second read-clock edge after a write.
- R6: `halfFull` is high while the write-side count is 256 or more. It rises right after the write edge that reaches 256. Reads reach it after two write-clock edges.
- R7: While `rstN` is low, `fullN` is high, `halfFull` is low and `emptyN` is low, with no clock edge needed. After `rstN` rises, the first two edges of each clock are ignored.
- R8: While `emptyN` is high, `rdData` shows the oldest stored word with no read edge. The first word written into an empty queue appears there.
- R9: `rdValid` equals `emptyN` AND NOT `outDisable`. `outDisable` has no effect on `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Active-low reset, asserted asynchronously |
| wrClk | input | 1 | Write clock; each rising edge is a store request |
| wrData | input | 18 | Word to store |
| rdClk | input | 1 | Read clock; each rising edge is a remove request |
| outDisable | input | 1 | High forces the valid qualifier low |
| rdData | output | 18 | Head word of the queue |
| rdValid | output | 1 | Head word is present and output is enabled |
| fullN | output | 1 | Low when 512 words are held |
| emptyN | output | 1 | Low when no words are held |
| halfFull | output | 1 | High when 256 or more words are held |

## Verification
A corrupt pointer or a Gray conversion fault shows first as a word out of order on `rdData`. The bench checks every word of a full 512-word pass, so such a fault fails on the first pop that reaches it. A synchronizer that is one stage short or long moves the edge where `emptyN` rises, or where `halfFull` and `fullN` clear after reads, by one clock. The bench samples these flags on each exact edge. A write let through while full, or during reset, shows up later as an extra word ahead of a known marker word.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  // strobes the control hands to the storage datapath
  typedef struct packed {
    logic push;   // store wrData at the write address on this write edge
    logic show;   // head word is valid for the consumer
  } fifoCtl_t;
endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  output logic srstN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srstN = chain[STAGES-1];
endmodule

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int PW     = 10,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] dout
);
  logic [PW-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          outDisable,
  output fifoCtl_t      ctl,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullN,
  output logic          emptyN,
  output logic          halfFull
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic wrSrstN, rdSrstN;

  fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_wrRst (.clk(wrClk), .arstN(rstN), .srstN(wrSrstN));
  fifo_rst_sync #(.STAGES(SYNC_STAGES)) u_rdRst (.clk(rdClk), .arstN(rstN), .srstN(rdSrstN));

  // write domain
  logic [PW-1:0] wrBin, wrGray, wrBinNext, rdGraySyncd, rdBinSyncd, wrFill;
  logic          push;

  fifo_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_rd2wr (
    .clk(wrClk), .rstN(wrSrstN), .din(rdGray), .dout(rdGraySyncd));

  assign rdBinSyncd = toBin(rdGraySyncd);
  assign wrFill     = wrBin - rdBinSyncd;
  assign fullN      = (wrFill != FULL_CNT);
  assign halfFull   = (wrFill >= HALF_CNT);
  assign push       = fullN & wrSrstN;
  assign wrBinNext  = wrBin + PW'(push);

  always_ff @(posedge wrClk or negedge wrSrstN) begin
    if (!wrSrstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
    end
  end

  // read domain
  logic [PW-1:0] rdBin, rdGray, rdBinNext, wrGraySyncd;
  logic          pop;

  fifo_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_wr2rd (
    .clk(rdClk), .rstN(rdSrstN), .din(wrGray), .dout(wrGraySyncd));

  assign emptyN    = (rdGray != wrGraySyncd);
  assign pop       = emptyN & rdSrstN;
  assign rdBinNext = rdBin + PW'(pop);

  always_ff @(posedge rdClk or negedge rdSrstN) begin
    if (!rdSrstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
    end
  end

  assign wrAddr   = wrBin[AW-1:0];
  assign rdAddr   = rdBin[AW-1:0];
  assign ctl.push = push;
  assign ctl.show = emptyN & ~outDisable;
endmodule

// File: rtl/fifo_dpath.sv
module fifo_dpath
  import fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  fifoCtl_t          ctl,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (ctl.push) store[wrAddr] <= wrData;
  end

  // head word is read straight from the array: first word falls through
  assign rdData  = store[rdAddr];
  assign rdValid = ctl.show;
endmodule

// File: rtl/dc_fwft_fifo.sv
module dc_fwft_fifo
  import fifo_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int DEPTH       = 512,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              outDisable,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              fullN,
  output logic              emptyN,
  output logic              halfFull
);
  fifoCtl_t      ctl;
  logic [AW-1:0] wrAddr, rdAddr;

  fifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .outDisable(outDisable),
    .ctl(ctl), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .emptyN(emptyN), .halfFull(halfFull));

  fifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .wrClk(wrClk), .ctl(ctl), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid));
endmodule

// File: rtl/dc_fwft_fifo_chk.sv
module dc_fwft_fifo_chk (
  input logic wrClk,
  input logic rdClk,
  input logic rstN,
  input logic outDisable,
  input logic rdValid,
  input logic fullN,
  input logic emptyN,
  input logic halfFull
);
  // R6: a full queue is always past the half mark
  a_r6_full_implies_half: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> halfFull);

  // R9: qualifier never claims data that is absent or disabled
  a_r9_valid_needs_data: assert property (@(posedge rdClk) disable iff (!rstN)
    rdValid |-> (emptyN && !outDisable));

  // R9: qualifier present whenever data is there and enabled
  a_r9_valid_when_data: assert property (@(posedge rdClk) disable iff (!rstN)
    (emptyN && !outDisable) |-> rdValid);

  // R7: write-side flags forced while reset is low
  a_r7_reset_wr_flags: assert property (@(posedge wrClk)
    !rstN |-> (fullN && !halfFull));

  // R7: read-side flag forced while reset is low
  a_r7_reset_rd_flag: assert property (@(posedge rdClk)
    !rstN |-> !emptyN);
endmodule

bind dc_fwft_fifo dc_fwft_fifo_chk u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .outDisable(outDisable),
  .rdValid(rdValid), .fullN(fullN), .emptyN(emptyN), .halfFull(halfFull));

// File: tb/sim_dc_fwft_fifo.sv
module sim_dc_fwft_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_P     = CLK_PERIOD / 2;
  localparam int DATA_W     = 18;
  localparam int DEPTH      = 512;
  localparam int WATCHDOG   = 100000 * CLK_PERIOD;

  // vector: [22] op (1 write, 0 read), [21] check data, [20] emptyN,
  //         [19] fullN, [18] halfFull, [17:0] write data or expected rdData
  localparam int NVEC = 11;
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00000},  // read while empty: R3
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 18'h000A1},  // write, not yet visible: R5
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00000},  // first sync edge: R5
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h000A1},  // falls through: R8
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h001B2},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'h003C3},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00000},  // pop, sync lags: R5
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h001B2},  // R1
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 18'h003C3},  // R1
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00000},  // last pop: R5
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 18'h00000}   // read while empty: R3
  };

  logic              rstN, wrClk, rdClk, outDisable;
  logic [DATA_W-1:0] wrData, rdData;
  logic              rdValid, fullN, emptyN, halfFull;
  int                checks = 0, fails = 0;
  bit                done = 0;

  dc_fwft_fifo u0 (
    .rstN(rstN), .wrClk(wrClk), .wrData(wrData), .rdClk(rdClk),
    .outDisable(outDisable), .rdData(rdData), .rdValid(rdValid),
    .fullN(fullN), .emptyN(emptyN), .halfFull(halfFull));

  function automatic logic [DATA_W-1:0] wordOf(input int i);
    return DATA_W'(i * 437) ^ 18'h2A5A5;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrPulse(input logic [DATA_W-1:0] d);
    wrData = d;
    #HALF_P wrClk = 1'b1;
    #HALF_P wrClk = 1'b0;
    #1;
  endtask

  task automatic rdPulse();
    #HALF_P rdClk = 1'b1;
    #HALF_P rdClk = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #WATCHDOG;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrClk = 1'b0; rdClk = 1'b0; outDisable = 1'b0; wrData = '0;
    #20;
    check("R7 reset fullN", 32'(fullN), 1);
    check("R7 reset emptyN", 32'(emptyN), 0);
    check("R7 reset halfFull", 32'(halfFull), 0);
    check("R9 reset rdValid", 32'(rdValid), 0);
    rstN = 1'b1;
    #5;
    for (int i = 0; i < 2; i++) begin wrPulse('0); rdPulse(); end

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][22]) wrPulse(VEC[v][17:0]);
      else            rdPulse();
      check($sformatf("R5 vec %0d emptyN", v), 32'(emptyN), 32'(VEC[v][20]));
      check($sformatf("R4 vec %0d fullN", v), 32'(fullN), 32'(VEC[v][19]));
      check($sformatf("R6 vec %0d halfFull", v), 32'(halfFull), 32'(VEC[v][18]));
      if (VEC[v][21]) check($sformatf("R8 vec %0d rdData", v), 32'(rdData), 32'(VEC[v][17:0]));
    end

    // fill to capacity
    for (int k = 1; k <= DEPTH; k++) begin
      wrPulse(wordOf(k - 1));
      if (k == 255) check("R6 255 held halfFull", 32'(halfFull), 0);
      if (k == 256) check("R6 256 held halfFull", 32'(halfFull), 1);
      if (k == 511) check("R4 511 held fullN", 32'(fullN), 1);
      if (k == 512) check("R4 512 held fullN", 32'(fullN), 0);
    end
    wrPulse(18'h3FFFF);  // dropped while full
    check("R2 write while full fullN", 32'(fullN), 0);

    rdPulse(); rdPulse();
    check("R5 visible after two read edges", 32'(emptyN), 1);
    for (int i = 0; i < 259; i++) begin
      check("R1 order part one", 32'(rdData), 32'(wordOf(i)));
      rdPulse();
    end

    // write side learns of reads only after two edges (no space before that)
    wrPulse(18'h3FFFF);
    check("R4 read not yet seen fullN", 32'(fullN), 0);
    check("R6 read not yet seen halfFull", 32'(halfFull), 1);
    wrPulse(18'h3FFFF);
    check("R4 read seen fullN", 32'(fullN), 1);
    check("R6 read seen halfFull", 32'(halfFull), 0);

    for (int i = 259; i < DEPTH; i++) begin
      check("R1 order part two", 32'(rdData), 32'(wordOf(i)));
      rdPulse();
    end
    check("R5 empty after last pop", 32'(emptyN), 0);
    rdPulse();
    check("R3 read while empty", 32'(emptyN), 0);

    wrPulse(18'h15A5A);
    rdPulse(); rdPulse();
    check("R2 marker first, nothing stored while full", 32'(rdData), 32'h15A5A);
    check("R8 marker visible", 32'(emptyN), 1);

    // output disable
    check("R9 valid enabled", 32'(rdValid), 1);
    outDisable = 1'b1; #2;
    check("R9 valid disabled", 32'(rdValid), 0);
    check("R9 data kept while disabled", 32'(rdData), 32'h15A5A);
    outDisable = 1'b0; #2;
    check("R9 valid restored", 32'(rdValid), 1);

    // reset with a word held
    rstN = 1'b0; #5;
    check("R7 async fullN", 32'(fullN), 1);
    check("R7 async emptyN", 32'(emptyN), 0);
    check("R7 async halfFull", 32'(halfFull), 0);
    rstN = 1'b1; #5;
    wrPulse(18'h2AAAA); wrPulse(18'h2AAAA);
    rdPulse(); rdPulse(); rdPulse(); rdPulse();
    check("R7 edges after release ignored", 32'(emptyN), 0);
    check("R7 fullN after release", 32'(fullN), 1);
    wrPulse(18'h0BEEF);
    rdPulse(); rdPulse();
    check("R8 first word after reset", 32'(rdData), 32'h0BEEF);
    check("R5 nonempty after reset write", 32'(emptyN), 1);
    rdPulse();
    check("R3 single pop empties", 32'(emptyN), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule